// File: doc/BRIEF.md
# Typed Integer Execution Unit

This block is the combinational integer datapath of a machine with 64-bit registers. The caller supplies an operation code, an operand kind and two 64-bit source values. The kind selects a 32-bit or 64-bit width and a signed or unsigned view. The block returns a 64-bit result in the same cycle. It covers addition, subtraction, the bitwise operations, complement, negation and shifts in both directions. A shift takes its distance either from the second source value or from a 6-bit constant field taken from the instruction.

Arithmetic wraps, and the block produces no carry, overflow or exception indication. When an operation is applied to a kind it does not support, the block forces the result to zero and raises a flag. The decode stage can then treat the instruction as malformed. Decoding, the register file, multiply, divide and floating point are handled elsewhere.

Top module: `talu_core`

## Requirements
- R1: Operand kind encoding on `kind_i` is: bit 0 = 1 for 64-bit width, bit 1 = 1 for signed. So 0 is unsigned 32-bit, 1 is unsigned 64-bit, 2 is signed 32-bit and 3 is signed 64-bit. Opcode 0 (add) returns a+b modulo 2^width for the unsigned kinds.
- R2: Opcode 1 (subtract) returns a-b modulo 2^width for the unsigned kinds.
- R3: Opcodes 2 (and), 3 (or), 4 (xor) and 5 (complement, ~a) are bitwise operations on the unsigned kinds.
- R4: Opcode 6 (negate) returns the two's-complement negation of a for the signed kinds. Negating the most negative value returns that same value.
- R5: For 32-bit kinds only bits 31:0 of the operands matter. Bits 63:32 of the result equal zero for the unsigned kind and copies of result bit 31 for the signed kind.
- R6: Opcode 7 shifts a left for the unsigned kinds, by the low bits of b. The distance is b[4:0] for 32-bit kinds and b[5:0] for 64-bit kinds. Higher bits of b are ignored.
- R7: Opcode 8 shifts right for all four kinds, with the same distance rule as R6. The shift fills with zeros for unsigned kinds and with copies of the operand sign bit (bit 31 or bit 63) for signed kinds.
- R8: Opcodes 9 (left, unsigned only) and 10 (right, all kinds) behave like opcodes 7 and 8. Their distance comes from `shamt_k_i`, masked the same way, and b is ignored.
- R9: A pairing that is not supported drives a zero result and sets `illegal_o`. This covers opcodes 0-5, 7 and 9 with a signed kind, opcode 6 with an unsigned kind, and opcodes 11-15 with any kind. `illegal_o` is low for every supported pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| kind_i | input | 2 | Operand kind: bit 0 width, bit 1 signedness |
| src_a_i | input | 64 | First source value |
| src_b_i | input | 64 | Second source value, also the register shift distance |
| shamt_k_i | input | 6 | Constant shift distance from the instruction |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | Unsupported opcode/kind pairing |

## Verification
The unit holds no state, so every result and the illegal flag are due in the same cycle the operands are applied, with zero cycles of latency. The bench applies a new operand set shortly after each rising edge. It compares both outputs at the following falling edge, so logic has settled and there is no race with the edge. Directed cases with hand-computed values cover the wrap, sign-fill, masking and illegal-pairing corners. A behavioural model, evaluated in the same cycle, then scores a long run of random operations.

// File: rtl/talu_pkg.sv
// Shared encodings for the typed integer execution unit.
// Assumes opcodes fit in 4 bits and kinds in 2 bits.
package talu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_COM   = 4'd5,
        OP_NEG   = 4'd6,
        OP_SHL   = 4'd7,
        OP_SHR   = 4'd8,
        OP_SHL_K = 4'd9,
        OP_SHR_K = 4'd10
    } talu_op_e;

    localparam int KIND_WIDE_BIT   = 0;
    localparam int KIND_SIGNED_BIT = 1;

endpackage

// File: rtl/talu_legal.sv
// Decides whether an opcode is defined for the given operand kind.
// Assumes the kind encoding of talu_pkg; undefined opcodes are never legal.
module talu_legal
    import talu_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic [1:0] kind_i,
    output logic       legal_o
);

    logic is_signed;
    assign is_signed = kind_i[KIND_SIGNED_BIT];

    // Legality table: unsigned-only, signed-only or any kind per opcode.
    always_comb begin
        case (talu_op_e'(op_i))
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_COM,
            OP_SHL, OP_SHL_K:  legal_o = !is_signed;
            OP_NEG:            legal_o = is_signed;
            OP_SHR, OP_SHR_K:  legal_o = 1'b1;
            default:           legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/talu_arith.sv
// Full-width add, subtract, bitwise logic, complement and negate.
// Assumes the caller truncates/extends for narrow kinds; low bits are exact.
module talu_arith
    import talu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  talu_op_e        op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] raw_o
);

    // Operation select with wrap-around arithmetic and checks of inverses.
    always_comb begin
        case (op_i)
            OP_ADD:  raw_o = a_i + b_i;
            OP_SUB:  raw_o = a_i - b_i;
            OP_AND:  raw_o = a_i & b_i;
            OP_OR:   raw_o = a_i | b_i;
            OP_XOR:  raw_o = a_i ^ b_i;
            OP_COM:  raw_o = ~a_i;
            OP_NEG:  raw_o = '0 - a_i;
            default: raw_o = '0;
        endcase

        if (op_i == OP_ADD)
            a_r1_add_undo: assert (raw_o - b_i == a_i);
        if (op_i == OP_SUB)
            a_r2_sub_undo: assert (raw_o + b_i == a_i);
        if (op_i == OP_COM)
            a_r3_com_disjoint: assert ((raw_o & a_i) == '0 && (raw_o | a_i) == '1);
        if (op_i == OP_NEG)
            a_r4_neg_sum_zero: assert (raw_o + a_i == '0);
    end

endmodule

// File: rtl/talu_shift.sv
// Left/right shifter with register or constant distance.
// Assumes narrow operands are pre-extended here so the low half of the
// full-width shift is exact; the caller extends the result afterwards.
module talu_shift #(
    parameter int XLEN = 64,
    localparam int SHW  = $clog2(XLEN),
    localparam int HLEN = XLEN / 2
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  amt_reg_i,
    input  logic [SHW-1:0]  amt_k_i,
    input  logic            use_k_i,
    input  logic            left_i,
    input  logic            arith_i,
    input  logic            wide_i,
    output logic [XLEN-1:0] raw_o
);

    logic [SHW-1:0]  amt_sel;
    logic [SHW-1:0]  amt_eff;
    logic [XLEN-1:0] opnd;

    // Pick the distance source and mask it to the operand width.
    always_comb begin
        amt_sel = use_k_i ? amt_k_i : amt_reg_i;
        amt_eff = wide_i ? amt_sel : {1'b0, amt_sel[SHW-2:0]};
    end

    // Prepare the operand: narrow values are zero- or sign-extended first.
    always_comb begin
        if (wide_i)
            opnd = a_i;
        else if (arith_i)
            opnd = {{HLEN{a_i[HLEN-1]}}, a_i[HLEN-1:0]};
        else
            opnd = {{HLEN{1'b0}}, a_i[HLEN-1:0]};
    end

    // Shift and check the fill bits entering from each end.
    always_comb begin
        if (left_i)
            raw_o = opnd << amt_eff;
        else if (arith_i)
            raw_o = $signed(opnd) >>> amt_eff;
        else
            raw_o = opnd >> amt_eff;

        if (left_i && amt_eff != '0)
            a_r6_left_zero_fill: assert (raw_o[0] == 1'b0);
        if (!left_i && !arith_i && wide_i && amt_eff != '0)
            a_r7_logical_zero_fill: assert (raw_o[XLEN-1] == 1'b0);
        if (!left_i && arith_i)
            a_r7_sign_kept: assert (raw_o[XLEN-1] == opnd[XLEN-1]);
    end

endmodule

// File: rtl/talu_core.sv
// Typed integer execution unit: combinational, one result per operand set.
// Assumes kind bit 0 = 64-bit width, bit 1 = signed. Unsupported pairings
// give a zero result plus illegal_o. No carry or overflow is produced.
module talu_core
    import talu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW  = $clog2(XLEN),
    localparam int HLEN = XLEN / 2
) (
    input  logic [3:0]      op_i,
    input  logic [1:0]      kind_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  logic [SHW-1:0]  shamt_k_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);

    talu_op_e        op;
    logic            legal;
    logic            wide;
    logic            sgn;
    logic            is_shift;
    logic            use_k;
    logic            left;
    logic [XLEN-1:0] arith_raw;
    logic [XLEN-1:0] shift_raw;
    logic [XLEN-1:0] raw;

    assign op   = talu_op_e'(op_i);
    assign wide = kind_i[KIND_WIDE_BIT];
    assign sgn  = kind_i[KIND_SIGNED_BIT];

    // Shift control decode from the opcode.
    always_comb begin
        is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SHL_K) || (op == OP_SHR_K);
        use_k    = (op == OP_SHL_K) || (op == OP_SHR_K);
        left     = (op == OP_SHL) || (op == OP_SHL_K);
    end

    talu_legal u_legal (
        .op_i    (op_i),
        .kind_i  (kind_i),
        .legal_o (legal)
    );

    talu_arith #(.XLEN(XLEN)) u_arith (
        .op_i  (op),
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .raw_o (arith_raw)
    );

    talu_shift #(.XLEN(XLEN)) u_shift (
        .a_i       (src_a_i),
        .amt_reg_i (src_b_i[SHW-1:0]),
        .amt_k_i   (shamt_k_i),
        .use_k_i   (use_k),
        .left_i    (left),
        .arith_i   (sgn),
        .wide_i    (wide),
        .raw_o     (shift_raw)
    );

    // Merge datapaths, apply narrow extension and the illegal-pairing zero.
    always_comb begin
        raw = is_shift ? shift_raw : arith_raw;
        if (!legal)
            result_o = '0;
        else if (wide)
            result_o = raw;
        else if (sgn)
            result_o = {{HLEN{raw[HLEN-1]}}, raw[HLEN-1:0]};
        else
            result_o = {{HLEN{1'b0}}, raw[HLEN-1:0]};
        illegal_o = !legal;

        if (legal && !wide && !sgn)
            a_r5_zero_upper: assert (result_o[XLEN-1:HLEN] == '0);
        if (legal && !wide && sgn)
            a_r5_sign_upper: assert (result_o[XLEN-1:HLEN] == {HLEN{result_o[HLEN-1]}});
        if (illegal_o)
            a_r9_illegal_zero: assert (result_o == '0);
    end

endmodule

// File: tb/talu_core_test.sv
// Bench: directed corner cases with hand values, then random operations
// scored against a behavioural model, one operand set per clock.
module talu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  kind_i = '0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic [5:0]  shamt_k_i = '0;
    logic [63:0] result_o;
    logic        illegal_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    talu_core uut (
        .op_i      (op_i),
        .kind_i    (kind_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .shamt_k_i (shamt_k_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    // Behavioural model of the requirements.
    function automatic logic [63:0] model(input int op, input int kind,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input int k, output bit bad);
        bit wide = (kind % 2) == 1;
        bit sgn  = kind >= 2;
        int amt;
        logic [63:0] r = '0;
        logic [31:0] lo;
        bad = 0;
        case (op)
            0: if (sgn) bad = 1; else r = a + b;
            1: if (sgn) bad = 1; else r = a - b;
            2: if (sgn) bad = 1; else r = a & b;
            3: if (sgn) bad = 1; else r = a | b;
            4: if (sgn) bad = 1; else r = a ^ b;
            5: if (sgn) bad = 1; else r = ~a;
            6: if (!sgn) bad = 1; else r = 64'd0 - a;
            7, 9: begin
                if (sgn) bad = 1;
                amt = ((op == 7) ? int'(b[5:0]) : k) % (wide ? 64 : 32);
                r = a << amt;
            end
            8, 10: begin
                amt = ((op == 8) ? int'(b[5:0]) : k) % (wide ? 64 : 32);
                lo = a[31:0];
                if (wide) r = sgn ? 64'($signed(a) >>> amt) : (a >> amt);
                else      r = sgn ? {32'd0, 32'($signed(lo) >>> amt)} : {32'd0, lo >> amt};
            end
            default: bad = 1;
        endcase
        if (bad) r = '0;
        else if (!wide) r = sgn ? {{32{r[31]}}, r[31:0]} : {32'd0, r[31:0]};
        return r;
    endfunction

    function automatic string tag_of(input int op, input int kind, input bit bad);
        string t;
        if (bad) return "R9";
        case (op)
            0: t = "R1";
            1: t = "R2";
            2, 3, 4, 5: t = "R3";
            6: t = "R4";
            7: t = "R6";
            8: t = "R7";
            default: t = "R8";
        endcase
        if (kind % 2 == 0) t = {t, "/R5"};
        return t;
    endfunction

    task automatic apply(input int op, input int kind, input logic [63:0] a,
                         input logic [63:0] b, input int k);
        @(posedge clk);
        #1;
        op_i = op[3:0]; kind_i = kind[1:0]; src_a_i = a; src_b_i = b; shamt_k_i = k[5:0];
        @(negedge clk);
    endtask

    task automatic score(input string req, input logic [63:0] exp_r, input bit exp_ill);
        checks++;
        if (result_o !== exp_r || illegal_o !== exp_ill) begin
            failures++;
            $display("FAIL %s: op=%0d kind=%0d got result=%h illegal=%b expected result=%h illegal=%b",
                     req, op_i, kind_i, result_o, illegal_o, exp_r, exp_ill);
        end
    endtask

    task automatic directed(input string req, input int op, input int kind,
                            input logic [63:0] a, input logic [63:0] b, input int k,
                            input logic [63:0] exp_r, input bit exp_ill);
        apply(op, kind, a, b, k);
        score(req, exp_r, exp_ill);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit bad;
        logic [63:0] e;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        score("R1 reset state", 64'd0, 1'b0);

        directed("R1", 0, 1, '1, 64'd1, 0, 64'd0, 0);
        directed("R1/R5", 0, 0, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001, 0, 64'd0, 0);
        directed("R2/R5", 1, 0, 64'd0, 64'd1, 0, 64'h0000_0000_FFFF_FFFF, 0);
        directed("R2", 1, 1, 64'd5, 64'd7, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0);
        directed("R3", 2, 1, 64'hF0F0_F0F0_0000_FFFF, 64'hFF00_FF00_FFFF_0F0F, 0, 64'hF000_F000_0000_0F0F, 0);
        directed("R3/R5", 5, 0, 64'hFFFF_FFFF_0000_00FF, 64'd0, 0, 64'h0000_0000_FFFF_FF00, 0);
        directed("R3", 4, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 0, 64'h5555_AAAA_5555_AAAA, 0);
        directed("R4/R5", 6, 2, 64'h1234_5678_0000_0001, 64'd0, 0, '1, 0);
        directed("R4", 6, 3, 64'h8000_0000_0000_0000, 64'd0, 0, 64'h8000_0000_0000_0000, 0);
        directed("R4/R5", 6, 2, 64'h0000_0000_8000_0000, 64'd0, 0, 64'hFFFF_FFFF_8000_0000, 0);
        directed("R7/R5", 8, 2, 64'h0000_0000_8000_0000, 64'd31, 0, '1, 0);
        directed("R7/R5", 8, 0, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, 64'd1, 0);
        directed("R7", 8, 3, 64'h8000_0000_0000_0000, 64'd4, 0, 64'hF800_0000_0000_0000, 0);
        directed("R7", 8, 1, 64'h8000_0000_0000_0000, 64'd4, 0, 64'h0800_0000_0000_0000, 0);
        directed("R6/R5", 7, 0, 64'd1, 64'hFF00_0000_0000_0021, 0, 64'd2, 0);
        directed("R6", 7, 1, 64'd1, 64'h0000_0000_0000_007F, 0, 64'h8000_0000_0000_0000, 0);
        directed("R5 sign from bit31", 7, 0, 64'd1, 64'd31, 0, 64'h0000_0000_8000_0000, 0);
        directed("R8", 9, 1, 64'd3, 64'd60, 2, 64'd12, 0);
        directed("R8/R5", 10, 2, 64'h0000_0000_F000_0000, 64'd1, 36, 64'hFFFF_FFFF_FF00_0000, 0);
        directed("R8", 10, 1, 64'hFF, 64'd0, 0, 64'hFF, 0);
        directed("R9", 0, 2, 64'd1, 64'd1, 0, 64'd0, 1);
        directed("R9", 6, 1, 64'd1, 64'd0, 0, 64'd0, 1);
        directed("R9", 9, 3, 64'd1, 64'd0, 1, 64'd0, 1);
        directed("R9", 13, 1, 64'd1, 64'd1, 0, 64'd0, 1);
        directed("R9", 15, 0, '1, '1, 63, 64'd0, 1);

        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 15);
            int kind = $urandom_range(0, 3);
            int k = $urandom_range(0, 63);
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            if (i % 4 == 0) b[5:0] = 6'd0;
            e = model(op, kind, a, b, k, bad);
            apply(op, kind, a, b, k);
            score(tag_of(op, kind, bad), e, bad);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule